// File: doc/BRIEF.md
# Set/Clear Programmable Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a processor as two request lines and one wake line. Each source has a three-bit trigger code. The code makes the source disabled, sensitive to a rising edge, a falling edge or both edges, or sensitive to a high or a low level. Detected rising and falling edges are held in two separate latch words until software acknowledges them.

Every per-source control field is its own register word with one bit per source. The fields are the three trigger-code planes, the mask, the wake enable, the request steering bit and the source enable. Software never writes these words directly. It writes ones to a set address or to a clear address, so bits written as zero never change. Two read-only status words show the pending, unmasked sources steered to each request line. A scratch test word completes the map.

Source inputs are treated as asynchronous and pass through a synchronizer before any detection. Accesses go over a simple strobe bus. A write updates state on the clock edge that samples the write strobe. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset every control, latch and test word reads as zero. `irq_req0`, `irq_req1` and `wake_out` are low, and `rdata` is zero.
- R2: `addr` is split as {field[5:2], op[1:0]}, with op 0 = read, 1 = set, 2 = clear and 3 = load. The fields are 0 trig0, 1 trig1, 2 trig2, 3 mask, 4 wake, 5 steer, 6 source enable, 7 rise latch, 8 fall latch, 9 status of request 0, 10 status of request 1 and 11 test. A set write ORs `wdata` into the field. A clear write removes the bits written as one. Bits written as zero keep their value, and a write to a read address changes nothing. `rdata` updates only in the cycle after a read strobe.
- R3: The trigger code of source i is {trig2[i], trig1[i], trig0[i]}. 001 is rising edge, 010 falling edge, 011 both edges, 101 high level and 110 low level. 000, 100 and 111 never make the source pending.
- R4: Rising and falling edges are latched in separate words. A clear write to field 7 acknowledges rising edges only, and a clear write to field 8 acknowledges falling edges only. A source in an edge mode stays pending while either of its latch bits is set.
- R5: A level-mode source is not latched. Its pending state follows the synchronized input, inverted for the low-level code, and it drops as soon as the input returns to the inactive level.
- R6: A pending, unmasked source with steer = 1 drives `irq_req0` and appears in status word 9. With steer = 0 it drives `irq_req1` and appears in status word 10.
- R7: Mask = 0 keeps a source out of both request lines and both status words. A latched edge survives and raises the request once the mask bit is set.
- R8: `wake_out` is high whenever a pending source has its wake bit set, whatever its mask bit.
- R9: With source enable = 0 a source latches no edge and is never pending.
- R10: Field 11 is a plain word, replaced as a whole by a load write and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Register address {field, op} |
| wdata | input | NUM_SRC | Write data, one bit per source |
| rdata | output | NUM_SRC | Registered read data |
| src_in | input | NUM_SRC | Asynchronous interrupt source inputs |
| irq_req0 | output | 1 | Request line 0 |
| irq_req1 | output | 1 | Request line 1 |
| wake_out | output | 1 | Wake indication |

## Verification
The bench builds the block with its default values: 32 sources and a two-stage synchronizer. With 32 sources, every one of the eight trigger codes can run on its own source bit in one pass of the vector table. The input levels before and after each transition are fixed per vector, so both edge polarities are checked against each edge code. The synchronizer depth sets how long the bench waits after an input change before it samples.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;

  localparam int unsigned FLD_W         = 4;
  localparam int unsigned OP_W          = 2;
  localparam int unsigned ADDR_W        = FLD_W + OP_W;
  localparam int unsigned NUM_SC_FIELDS = 7;

  typedef enum logic [OP_W-1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_LOAD = 2'd3
  } op_e;

  typedef enum logic [FLD_W-1:0] {
    FLD_TRIG0 = 4'd0,
    FLD_TRIG1 = 4'd1,
    FLD_TRIG2 = 4'd2,
    FLD_MASK  = 4'd3,
    FLD_WAKE  = 4'd4,
    FLD_STEER = 4'd5,
    FLD_SRCEN = 4'd6,
    FLD_RISE  = 4'd7,
    FLD_FALL  = 4'd8,
    FLD_STAT0 = 4'd9,
    FLD_STAT1 = 4'd10,
    FLD_TEST  = 4'd11
  } fld_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_level;
    logic level_low;
  } trig_dec_t;

  // Code is {trig2, trig1, trig0}; unlisted codes decode to no sensitivity.
  function automatic trig_dec_t decode_trig(input logic [2:0] code);
    trig_dec_t d;
    d = '0;
    case (code)
      3'b001: d.on_rise = 1'b1;
      3'b010: d.on_fall = 1'b1;
      3'b011: begin
        d.on_rise = 1'b1;
        d.on_fall = 1'b1;
      end
      3'b101: d.on_level = 1'b1;
      3'b110: begin
        d.on_level  = 1'b1;
        d.level_low = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/irq_sc_sync.sv
module irq_sc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = d;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/irq_sc_bitreg.sv
module irq_sc_bitreg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             load_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;
  logic             upd;

  assign upd = set_en | clr_en | load_en;

  always_comb begin
    q_d = q;
    if (load_en)     q_d = wdata;
    else if (set_en) q_d = q | wdata;
    else if (clr_en) q_d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end

  AST_SET_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !load_en) |=> (((q & $past(wdata)) == $past(wdata)) &&
                              ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))); // R2
  AST_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && !load_en) |=> (((q & $past(wdata)) == '0) &&
                              ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en || load_en) |=> $stable(q)); // R2

endmodule

// File: rtl/irq_sc_detect.sv
module irq_sc_detect
  import irq_sc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] trig0,
  input  logic [WIDTH-1:0] trig1,
  input  logic [WIDTH-1:0] trig2,
  input  logic [WIDTH-1:0] srcen,
  input  logic             rise_ack_en,
  input  logic             fall_ack_en,
  input  logic [WIDTH-1:0] ack_data,
  output logic [WIDTH-1:0] rise_q,
  output logic [WIDTH-1:0] fall_q,
  output logic [WIDTH-1:0] pend
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise_hit, fall_hit, lvl_hit, edge_mode;
  logic [WIDTH-1:0] rise_d, fall_d, rise_ack, fall_ack;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_src
      trig_dec_t dec;
      assign dec          = decode_trig({trig2[i], trig1[i], trig0[i]});
      assign rise_hit[i]  = srcen[i] & dec.on_rise & sync_in[i] & ~prev_q[i];
      assign fall_hit[i]  = srcen[i] & dec.on_fall & ~sync_in[i] & prev_q[i];
      assign lvl_hit[i]   = srcen[i] & dec.on_level & (sync_in[i] ^ dec.level_low);
      assign edge_mode[i] = srcen[i] & (dec.on_rise | dec.on_fall);
      assign pend[i]      = lvl_hit[i] | (edge_mode[i] & (rise_q[i] | fall_q[i]));

      AST_RISE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q[i] && !(rise_ack_en && ack_data[i])) |=> rise_q[i]); // R4
      AST_FALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q[i] && !(fall_ack_en && ack_data[i])) |=> fall_q[i]); // R4
      AST_RISE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rise_q[i]) |-> $past(srcen[i] && trig0[i] && !trig2[i])); // R9
      AST_FALL_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_q[i]) |-> $past(srcen[i] && trig1[i] && !trig2[i])); // R3
    end
  endgenerate

  // A new edge in the acknowledge cycle wins over the acknowledge.
  always_comb begin
    rise_ack = rise_ack_en ? ack_data : '0;
    fall_ack = fall_ack_en ? ack_data : '0;
    rise_d   = (rise_q & ~rise_ack) | rise_hit;
    fall_d   = (fall_q & ~fall_ack) | fall_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      prev_q <= sync_in;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irq_sc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_req0,
  output logic               irq_req1,
  output logic               wake_out
);

  logic [FLD_W-1:0]   a_fld;
  logic [OP_W-1:0]    a_op;
  logic [NUM_SRC-1:0] sc_q [NUM_SC_FIELDS];
  logic [NUM_SRC-1:0] test_q;
  logic [NUM_SRC-1:0] sync_in, rise_q, fall_q, pend;
  logic [NUM_SRC-1:0] stat0, stat1, rd_mux, rdata_d;
  logic               rise_ack_en, fall_ack_en, test_load;

  assign a_fld = addr[ADDR_W-1:OP_W];
  assign a_op  = addr[OP_W-1:0];

  generate
    for (genvar f = 0; f < NUM_SC_FIELDS; f++) begin : g_fld
      logic hit;
      assign hit = wr_en && (a_fld == FLD_W'(f));
      irq_sc_bitreg #(.WIDTH(NUM_SRC)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (hit && (a_op == OP_SET)),
        .clr_en  (hit && (a_op == OP_CLR)),
        .load_en (1'b0),
        .wdata   (wdata),
        .q       (sc_q[f])
      );
    end
  endgenerate

  assign test_load = wr_en && (a_fld == FLD_TEST) && (a_op == OP_LOAD);

  irq_sc_bitreg #(.WIDTH(NUM_SRC)) u_test (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (1'b0),
    .clr_en  (1'b0),
    .load_en (test_load),
    .wdata   (wdata),
    .q       (test_q)
  );

  irq_sc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_in),
    .q     (sync_in)
  );

  assign rise_ack_en = wr_en && (a_fld == FLD_RISE) && (a_op == OP_CLR);
  assign fall_ack_en = wr_en && (a_fld == FLD_FALL) && (a_op == OP_CLR);

  irq_sc_detect #(.WIDTH(NUM_SRC)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_in     (sync_in),
    .trig0       (sc_q[FLD_TRIG0]),
    .trig1       (sc_q[FLD_TRIG1]),
    .trig2       (sc_q[FLD_TRIG2]),
    .srcen       (sc_q[FLD_SRCEN]),
    .rise_ack_en (rise_ack_en),
    .fall_ack_en (fall_ack_en),
    .ack_data    (wdata),
    .rise_q      (rise_q),
    .fall_q      (fall_q),
    .pend        (pend)
  );

  assign stat0    = pend & sc_q[FLD_MASK] & sc_q[FLD_STEER];
  assign stat1    = pend & sc_q[FLD_MASK] & ~sc_q[FLD_STEER];
  assign irq_req0 = |stat0;
  assign irq_req1 = |stat1;
  assign wake_out = |(pend & sc_q[FLD_WAKE]);

  always_comb begin
    rd_mux = '0;
    if (a_op == OP_READ) begin
      case (a_fld)
        FLD_TRIG0: rd_mux = sc_q[FLD_TRIG0];
        FLD_TRIG1: rd_mux = sc_q[FLD_TRIG1];
        FLD_TRIG2: rd_mux = sc_q[FLD_TRIG2];
        FLD_MASK:  rd_mux = sc_q[FLD_MASK];
        FLD_WAKE:  rd_mux = sc_q[FLD_WAKE];
        FLD_STEER: rd_mux = sc_q[FLD_STEER];
        FLD_SRCEN: rd_mux = sc_q[FLD_SRCEN];
        FLD_RISE:  rd_mux = rise_q;
        FLD_FALL:  rd_mux = fall_q;
        FLD_STAT0: rd_mux = stat0;
        FLD_STAT1: rd_mux = stat1;
        FLD_TEST:  rd_mux = test_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  assign rdata_d = rd_en ? rd_mux : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2
  AST_REQ0_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req0 |-> |(sc_q[FLD_MASK] & sc_q[FLD_STEER] & sc_q[FLD_SRCEN])); // R6
  AST_REQ1_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req1 |-> |(sc_q[FLD_MASK] & ~sc_q[FLD_STEER] & sc_q[FLD_SRCEN])); // R6
  AST_WAKE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> |(sc_q[FLD_WAKE] & sc_q[FLD_SRCEN])); // R8

endmodule

// File: tb/irq_setclr_ctrl_tb.sv
module irq_setclr_ctrl_tb;

  localparam int N = 32;
  // field codes
  localparam int F_T0 = 0, F_T1 = 1, F_T2 = 2, F_MASK = 3, F_WAKE = 4, F_STEER = 5;
  localparam int F_SRCEN = 6, F_RISE = 7, F_FALL = 8, F_ST0 = 9, F_ST1 = 10, F_TEST = 11;
  localparam int O_RD = 0, O_SET = 1, O_CLR = 2, O_LOAD = 3;

  // {code[2:0], input before, input after, expected pending}
  localparam int NV = 15;
  localparam logic [5:0] VEC [NV] = '{
    6'b000_01_0, 6'b001_01_1, 6'b001_10_0, 6'b010_10_1, 6'b010_01_0,
    6'b011_01_1, 6'b011_10_1, 6'b101_11_1, 6'b101_00_0, 6'b110_00_1,
    6'b110_11_0, 6'b100_01_0, 6'b111_10_0, 6'b100_11_0, 6'b111_00_0
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_en;
  logic [5:0]   addr;
  logic [N-1:0] wdata, rdata, src_in;
  logic         irq_req0, irq_req1, wake_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_setclr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in),
    .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_out(wake_out)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int f, input int op, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {f[3:0], op[1:0]}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input int f, output logic [N-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = {f[3:0], 2'd0};
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_in = '0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rd, m0, m1, m2, en;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; src_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 req0", {31'd0, irq_req0}, '0);
    chk("R1 req1", {31'd0, irq_req1}, '0);
    chk("R1 wake", {31'd0, wake_out}, '0);
    chk("R1 rdata", rdata, '0);
    bus_rd(F_MASK, rd);  chk("R1 mask", rd, '0);
    bus_rd(F_T2, rd);    chk("R1 trig2", rd, '0);
    bus_rd(F_TEST, rd);  chk("R1 test", rd, '0);

    // R3 vector table: source v gets code VEC[v]
    m0 = '0; m1 = '0; m2 = '0; en = '0;
    for (int v = 0; v < NV; v++) begin
      m0[v] = VEC[v][3]; m1[v] = VEC[v][4]; m2[v] = VEC[v][5]; en[v] = 1'b1;
    end
    bus_wr(F_T0, O_SET, m0);
    bus_wr(F_T1, O_SET, m1);
    bus_wr(F_T2, O_SET, m2);
    bus_wr(F_SRCEN, O_SET, en);
    bus_wr(F_MASK, O_SET, en);
    bus_wr(F_STEER, O_SET, en);
    for (int v = 0; v < NV; v++) begin
      src_in[v] = VEC[v][2];
      idle(5);
      bus_wr(F_RISE, O_CLR, 32'd1 << v);
      bus_wr(F_FALL, O_CLR, 32'd1 << v);
      src_in[v] = VEC[v][1];
      idle(5);
      bus_rd(F_ST0, rd);
      chk($sformatf("R3 code %b %b->%b", VEC[v][5:3], VEC[v][2], VEC[v][1]),
          {31'd0, rd[v]}, {31'd0, VEC[v][0]});
    end

    do_reset();

    // R2 set/clear semantics
    bus_wr(F_MASK, O_SET, 32'hF0F0_0000);
    bus_wr(F_MASK, O_SET, 32'h0000_00FF);
    bus_rd(F_MASK, rd); chk("R2 set accumulates", rd, 32'hF0F0_00FF);
    bus_wr(F_MASK, O_CLR, 32'hF000_00F0);
    bus_rd(F_MASK, rd); chk("R2 clear only ones", rd, 32'h00F0_000F);
    bus_wr(F_MASK, O_RD, 32'hFFFF_FFFF);
    bus_rd(F_MASK, rd); chk("R2 write to read addr ignored", rd, 32'h00F0_000F);
    bus_wr(F_MASK, O_CLR, 32'hFFFF_FFFF);
    bus_rd(F_MASK, rd); chk("R2 clear all", rd, '0);

    // R10 test word
    bus_wr(F_TEST, O_LOAD, 32'h5A5A_A5A5);
    bus_rd(F_TEST, rd); chk("R10 test load", rd, 32'h5A5A_A5A5);
    bus_wr(F_TEST, O_LOAD, 32'h0000_0003);
    bus_rd(F_TEST, rd); chk("R10 test replace", rd, 32'h0000_0003);

    // R6 steering: source 0 high level
    bus_wr(F_T0, O_SET, 32'h1);
    bus_wr(F_T2, O_SET, 32'h1);
    bus_wr(F_SRCEN, O_SET, 32'h1);
    bus_wr(F_MASK, O_SET, 32'h1);
    bus_wr(F_STEER, O_SET, 32'h1);
    src_in[0] = 1'b1;
    idle(4);
    chk("R6 req0 on steer=1", {31'd0, irq_req0}, 32'd1);
    chk("R6 req1 off steer=1", {31'd0, irq_req1}, 32'd0);
    bus_rd(F_ST0, rd); chk("R6 status0", rd, 32'h1);
    bus_wr(F_STEER, O_CLR, 32'h1);
    chk("R6 req1 on steer=0", {31'd0, irq_req1}, 32'd1);
    chk("R6 req0 off steer=0", {31'd0, irq_req0}, 32'd0);
    bus_rd(F_ST1, rd); chk("R6 status1", rd, 32'h1);

    // R7 mask blocks
    bus_wr(F_MASK, O_CLR, 32'h1);
    chk("R7 masked req1", {31'd0, irq_req1}, 32'd0);
    bus_rd(F_ST1, rd); chk("R7 masked status1", rd, '0);

    // R8 wake independent of mask
    bus_wr(F_WAKE, O_SET, 32'h1);
    chk("R8 wake while masked", {31'd0, wake_out}, 32'd1);
    bus_wr(F_WAKE, O_CLR, 32'h1);
    chk("R8 wake cleared", {31'd0, wake_out}, 32'd0);
    src_in[0] = 1'b0;
    idle(4);

    // R4/R7 source 1 both edges, masked, steer 0
    bus_wr(F_T0, O_SET, 32'h2);
    bus_wr(F_T1, O_SET, 32'h2);
    bus_wr(F_SRCEN, O_SET, 32'h2);
    src_in[1] = 1'b1; idle(4);
    src_in[1] = 1'b0; idle(4);
    bus_rd(F_RISE, rd); chk("R4 rise latched", rd, 32'h2);
    bus_rd(F_FALL, rd); chk("R4 fall latched", rd, 32'h2);
    chk("R7 masked edge no req", {31'd0, irq_req1}, 32'd0);
    bus_wr(F_MASK, O_SET, 32'h2);
    chk("R7 latch survives mask", {31'd0, irq_req1}, 32'd1);
    bus_wr(F_RISE, O_CLR, 32'h2);
    bus_rd(F_RISE, rd); chk("R4 rise acked", rd, '0);
    bus_rd(F_FALL, rd); chk("R4 fall kept", rd, 32'h2);
    chk("R4 still pending via fall", {31'd0, irq_req1}, 32'd1);
    bus_wr(F_FALL, O_CLR, 32'h2);
    chk("R4 both acked", {31'd0, irq_req1}, 32'd0);

    // R9 source 2 rising, not enabled
    bus_wr(F_T0, O_SET, 32'h4);
    bus_wr(F_MASK, O_SET, 32'h4);
    bus_wr(F_STEER, O_SET, 32'h4);
    src_in[2] = 1'b1; idle(4);
    bus_rd(F_RISE, rd); chk("R9 no latch when disabled", rd, '0);
    chk("R9 no req when disabled", {31'd0, irq_req0}, 32'd0);
    src_in[2] = 1'b0; idle(4);

    // R5 source 3 low level
    bus_wr(F_T1, O_SET, 32'h8);
    bus_wr(F_T2, O_SET, 32'h8);
    bus_wr(F_SRCEN, O_SET, 32'h8);
    bus_wr(F_MASK, O_SET, 32'h8);
    bus_wr(F_STEER, O_SET, 32'h8);
    idle(1);
    chk("R5 low level asserted", {31'd0, irq_req0}, 32'd1);
    src_in[3] = 1'b1; idle(4);
    chk("R5 high input releases", {31'd0, irq_req0}, 32'd0);
    src_in[3] = 1'b0; idle(4);
    chk("R5 low again", {31'd0, irq_req0}, 32'd1);
    src_in[3] = 1'b1; idle(4);
    chk("R5 not latched", {31'd0, irq_req0}, 32'd0);
    bus_rd(F_ST0, rd); chk("R5 status follows", rd, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule